// File: doc/BRIEF.md
# Key-Gated Control Register Bank

This block is a small byte-wide register file on a plain synchronous bus. It holds a bank of fourteen control bytes and a separate protect register. A write changes a control byte only while the protect register holds the unlock key 0x96. A write that arrives while the bank is locked completes like any other write and signals no error. The targeted byte simply keeps its value. Reads are never gated.

Software unlocks the bank by writing the key to the protect register. It may then rewrite control bytes any number of times. It locks the bank again by writing any other value to the protect register.

The lock logic is a two-state machine. LOCKED is the state after reset. The transition UNLOCK moves LOCKED to UNLOCKED on a protect write whose data equals the key. The transition RELOCK moves UNLOCKED to LOCKED on a protect write whose data is anything else. Every other cycle holds the current state. Control writes are judged against the state held at the start of the cycle.

Top module: `wpr_bank`

## Requirements
- R1: After reset, the protect register (offset 0x10) reads 0x00 and the bank is locked. The control byte at offset i (0x00 to 0x0D) reads 0xA0 + i.
- R2: A write of 0x96 to offset 0x10 unlocks the bank, starting with the next cycle.
- R3: A write of any value other than 0x96 to offset 0x10 locks the bank, starting with the next cycle.
- R4: A write to offset 0x10 is always accepted, in either state. Reading 0x10 returns the full byte last written there.
- R5: While the bank is locked, a write to offsets 0x00 to 0x0D leaves the addressed byte unchanged.
- R6: While the bank is unlocked, a write to offsets 0x00 to 0x0D stores the data. It reads back from the next cycle, and the byte may be rewritten repeatedly.
- R7: A control write in the cycle right after a protect write follows the new lock state. The write that changes the lock state can never modify a control byte itself.
- R8: Writes to offsets 0x0E, 0x0F and 0x11 to 0xFF are ignored. Reads of those offsets return 0x00.
- R9: Locking and unlocking leave every control byte unchanged.
- R10: bus_rdata shows the byte at bus_addr in the same cycle, with no wait state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |

## Verification
The assertions assume one access per cycle. They also assume bus_addr, bus_wr and bus_wdata are stable around each rising edge, and that reset is asserted before the first edge. The bench changes its inputs only on falling edges and always drives defined values. It draws addresses so that control, protect, gap and far offsets all occur. It also skews write data toward the key, so the UNLOCK and RELOCK transitions are exercised often and in both orders.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

    typedef enum logic [0:0] {
        ST_LOCKED   = 1'b0,
        ST_UNLOCKED = 1'b1
    } lock_state_e;

    function automatic logic [7:0] ctrl_rst_val(input int idx);
        return 8'hA0 + 8'(idx);
    endfunction

endpackage

// File: rtl/wpr_lock_fsm.sv
module wpr_lock_fsm
    import wpr_pkg::*;
#(
    parameter int          DATA_W = 8,
    parameter logic [DATA_W-1:0] KEY = DATA_W'(8'h96)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlock_o,
    output logic [DATA_W-1:0] prot_q_o
);

    lock_state_e       state_q, state_d;
    logic [DATA_W-1:0] prot_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED:   if (prot_wr && wdata == KEY) state_d = ST_UNLOCKED;
            ST_UNLOCKED: if (prot_wr && wdata != KEY) state_d = ST_LOCKED;
            default:     state_d = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
            prot_q  <= '0;
        end else begin
            state_q <= state_d;
            if (prot_wr) prot_q <= wdata;
        end
    end

    always_comb begin
        unlock_o = (state_q == ST_UNLOCKED);
        prot_q_o = prot_q;
    end

    p_key_unlocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_wr && wdata == KEY) |=> unlock_o);

    p_other_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_wr && wdata != KEY) |=> !unlock_o);

    p_prot_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prot_wr |=> (prot_q_o == $past(wdata)));

    p_state_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_wr |=> $stable(unlock_o));

endmodule

// File: rtl/wpr_addr_dec.sv
module wpr_addr_dec #(
    parameter int                ADDR_W    = 8,
    parameter int                NUM_CTRL  = 14,
    parameter logic [ADDR_W-1:0] CTRL_BASE = '0,
    parameter logic [ADDR_W-1:0] PROT_ADDR = ADDR_W'(8'h10),
    localparam int               IDX_W     = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              ctrl_hit,
    output logic              prot_hit,
    output logic [IDX_W-1:0]  ctrl_idx
);

    localparam logic [ADDR_W-1:0] CTRL_END = CTRL_BASE + ADDR_W'(NUM_CTRL);

    logic [ADDR_W-1:0] offs;

    always_comb begin
        offs     = addr - CTRL_BASE;
        ctrl_hit = (addr >= CTRL_BASE) && (addr < CTRL_END);
        prot_hit = (addr == PROT_ADDR);
        ctrl_idx = IDX_W'(offs);
    end

endmodule

// File: rtl/wpr_ctrl_bank.sv
module wpr_ctrl_bank
    import wpr_pkg::*;
#(
    parameter int  DATA_W   = 8,
    parameter int  NUM_CTRL = 14,
    localparam int IDX_W    = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr,
    input  logic                             ctrl_hit,
    input  logic [IDX_W-1:0]                 ctrl_idx,
    input  logic                             unlock_i,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_CTRL-1:0][DATA_W-1:0]  regs_o
);

    for (genvar gi = 0; gi < NUM_CTRL; gi++) begin : g_reg
        logic we;
        logic [DATA_W-1:0] q;

        always_comb we = wr && ctrl_hit && unlock_i && (ctrl_idx == IDX_W'(gi));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q <= DATA_W'(ctrl_rst_val(gi));
            else if (we) q <= wdata;
        end

        always_comb regs_o[gi] = q;

        p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !unlock_i |=> $stable(regs_o[gi]));

        p_unlocked_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (unlock_i && wr && ctrl_hit && ctrl_idx == IDX_W'(gi))
            |=> (regs_o[gi] == $past(wdata)));
    end

endmodule

// File: rtl/wpr_read_mux.sv
module wpr_read_mux #(
    parameter int  DATA_W   = 8,
    parameter int  NUM_CTRL = 14,
    localparam int IDX_W    = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ctrl_hit,
    input  logic                            prot_hit,
    input  logic [IDX_W-1:0]                ctrl_idx,
    input  logic [NUM_CTRL-1:0][DATA_W-1:0] regs,
    input  logic [DATA_W-1:0]               prot_q,
    output logic [DATA_W-1:0]               rdata
);

    always_comb begin
        rdata = '0;
        if (prot_hit)      rdata = prot_q;
        else if (ctrl_hit) rdata = regs[ctrl_idx];
    end

    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_hit && !prot_hit) |-> (rdata == '0));

    p_prot_visible_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prot_hit |-> (rdata == prot_q));

endmodule

// File: rtl/wpr_bank.sv
module wpr_bank
    import wpr_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 8,
    parameter int          NUM_CTRL = 14,
    parameter logic [7:0]  KEY      = 8'h96,
    parameter logic [7:0]  PROT_OFF = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int IDX_W = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1;

    logic                            ctrl_hit, prot_hit, unlock;
    logic [IDX_W-1:0]                ctrl_idx;
    logic [DATA_W-1:0]               prot_q;
    logic [NUM_CTRL-1:0][DATA_W-1:0] regs;

    wpr_addr_dec #(
        .ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL),
        .CTRL_BASE('0), .PROT_ADDR(ADDR_W'(PROT_OFF))
    ) u_dec (
        .addr(bus_addr), .ctrl_hit(ctrl_hit),
        .prot_hit(prot_hit), .ctrl_idx(ctrl_idx)
    );

    wpr_lock_fsm #(.DATA_W(DATA_W), .KEY(DATA_W'(KEY))) u_lock (
        .clk(clk), .rst_n(rst_n), .prot_wr(bus_wr && prot_hit),
        .wdata(bus_wdata), .unlock_o(unlock), .prot_q_o(prot_q)
    );

    wpr_ctrl_bank #(.DATA_W(DATA_W), .NUM_CTRL(NUM_CTRL)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .ctrl_hit(ctrl_hit),
        .ctrl_idx(ctrl_idx), .unlock_i(unlock), .wdata(bus_wdata),
        .regs_o(regs)
    );

    wpr_read_mux #(.DATA_W(DATA_W), .NUM_CTRL(NUM_CTRL)) u_rmux (
        .clk(clk), .rst_n(rst_n), .ctrl_hit(ctrl_hit), .prot_hit(prot_hit),
        .ctrl_idx(ctrl_idx), .regs(regs), .prot_q(prot_q), .rdata(bus_rdata)
    );

    p_relock_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && prot_hit && bus_wdata != DATA_W'(KEY)) |=> ##1 $stable(regs));

endmodule

// File: tb/wpr_bank_tb.sv
module wpr_bank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCTRL      = 14;
    localparam logic [7:0] KEY  = 8'h96;
    localparam logic [7:0] PROT = 8'h10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_ctrl [NCTRL];
    logic [7:0] m_prot;

    always #(CLK_PERIOD/2) clk = ~clk;

    wpr_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (a < 8'(NCTRL)) return m_ctrl[a];
        if (a == PROT)     return m_prot;
        return 8'h00;
    endfunction

    function automatic bit model_unlocked();
        return m_prot == KEY;
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // drive on falling edge, take effect at next rising edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(posedge clk);
        if (a < 8'(NCTRL)) begin
            if (model_unlocked()) m_ctrl[a] = d;
        end else if (a == PROT) begin
            m_prot = d;
        end
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1;
        check(bus_rdata, exp_read(a), req);
    endtask

    function automatic string tag_of(input logic [7:0] a);
        if (a < 8'(NCTRL)) return model_unlocked() ? "R6" : "R5";
        if (a == PROT)     return "R4";
        return "R8";
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd1234);
        for (int i = 0; i < NCTRL; i++) m_ctrl[i] = 8'hA0 + 8'(i);
        m_prot = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset values
        for (int i = 0; i < NCTRL; i++) rd(8'(i), "R1");
        rd(PROT, "R1");

        // R5: locked writes discarded
        wr(8'h03, 8'h55); rd(8'h03, "R5");
        wr(8'h0D, 8'h11); rd(8'h0D, "R5");

        // R2/R6: unlock then repeated writes
        wr(PROT, KEY); rd(PROT, "R2");
        wr(8'h03, 8'h55); rd(8'h03, "R2");
        wr(8'h03, 8'h66); rd(8'h03, "R6");
        wr(8'h00, 8'h01); rd(8'h00, "R6");
        wr(8'h0D, 8'hFE); rd(8'h0D, "R6");

        // R8: gap and far offsets
        wr(8'h0E, 8'h77); rd(8'h0E, "R8");
        wr(8'h0F, 8'h77); rd(8'h0F, "R8");
        wr(8'hFF, 8'h77); rd(8'hFF, "R8");
        rd(8'h11, "R8");

        // R7: back-to-back relock then control write is blocked
        wr(PROT, 8'h97);
        wr(8'h05, 8'hC3);
        rd(8'h05, "R7");
        rd(PROT, "R4");
        // R7: back-to-back unlock then control write is taken
        wr(PROT, KEY);
        wr(8'h06, 8'h3C);
        rd(8'h06, "R7");

        // R9: lock/unlock cycle leaves contents
        wr(PROT, 8'h00); wr(PROT, KEY); wr(PROT, 8'h5A);
        for (int i = 0; i < NCTRL; i++) rd(8'(i), "R9");
        rd(PROT, "R4");

        // R10: same-cycle read while address changes each cycle
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); bus_wr = 1'b0; bus_addr = 8'(i * 3);
            #1 check(bus_rdata, exp_read(8'(i * 3)), "R10");
        end

        // R3: random traffic with key-heavy protect writes
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a, d;
            int sel;
            string t;
            sel = $urandom_range(0, 9);
            if (sel < 5)       a = 8'($urandom_range(0, NCTRL - 1));
            else if (sel < 8)  a = PROT;
            else if (sel == 8) a = 8'($urandom_range(14, 15));
            else               a = 8'($urandom_range(17, 255));
            d = ($urandom_range(0, 1) == 1) ? KEY : 8'($urandom);
            t = (a == PROT) ? ((d == KEY) ? "R2" : "R3") : tag_of(a);
            if ($urandom_range(0, 3) != 0) begin
                wr(a, d);
                rd(a, t);
            end else begin
                rd(a, t);
            end
            rd(8'($urandom), "R10");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule